// File: doc/BRIEF.md
# Flushable Ready/Valid FIFO Queue

This block is a first-in first-out queue with a valid/ready handshake on its input and output sides. It also has an occupancy count and a synchronous flush. A producer offers a word with `in_valid` and the queue takes it when `in_ready` is high. A consumer takes the head word when `out_valid` and `out_ready` are both high. Back-pressure works in both directions. `in_ready` falls only when every slot is occupied. `out_valid` falls only when no slot is occupied. Neither ready signal depends on the other side's valid in the same cycle.

A single-cycle `flush` empties the queue, and the queue is empty from the next cycle on. The same-cycle rules are fixed. A dequeue handshake in the flush cycle still delivers the current head word. A word offered and accepted in the flush cycle is discarded. Depth, data width and the storage style are parameters. Storage is either registers read combinationally or a memory read synchronously with a look-ahead address. Both styles give the same port behaviour.

Top module: `fifo_flush_q`

## Requirements
- R1: A word moves on a side only when that side's valid and ready are both high; `in_ready` is low exactly when `count` equals DEPTH, and `out_valid` is high exactly when `count` is non-zero.
- R2: With `flush` low, words leave in the order they were accepted, with no loss and no duplication, and a head word that is not taken holds its value.
- R3: On the cycle after `flush` is high, `count` is 0, `out_valid` is low and `in_ready` is high, whatever the occupancy was, including a full queue.
- R4: A word accepted in a cycle where `flush` is high is discarded; the first word out afterwards is the first word accepted after the flush.
- R5: When the queue is not empty and `flush` is high, `out_valid` stays high in that cycle, and a handshake then returns the current head word.
- R6: Flushing an empty queue has no side effect; words accepted afterwards pass through in order.
- R7: `count` gives the number of stored words, from 0 to DEPTH, and is ceil(log2(DEPTH+1)) bits wide. When an enqueue and a dequeue both fire without flush, `count` is unchanged.
- R8: With `rst` high at a clock edge, the queue is empty after that edge: `count` 0, `out_valid` low and `in_ready` high.
- R9: Pointers wrap from DEPTH-1 to 0 for any depth, including depths that are not a power of two, and both storage styles (SYNC_READ 0 and 1) produce identical port sequences.
- R10: There is no combinational path from `in_valid` to `out_valid`: a word offered to an empty queue is visible at the output no earlier than the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Discard all stored words this cycle |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Queue can accept a word |
| in_data | input | WIDTH | Word offered by the producer |
| out_valid | output | 1 | Head word is present on `out_data` |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | WIDTH | Head word |
| count | output | ceil(log2(DEPTH+1)) | Number of stored words |

## Verification
The case that is hardest to reach from the ports is a flush that meets a live dequeue handshake and an accepted enqueue in the same cycle while the read pointer sits away from zero. This case checks at once that the head word is delivered, that the new word is dropped, and that the look-ahead read of the synchronous memory is re-aimed at slot 0. The stimulus gets there in three steps. A stream of simultaneous pushes and pops walks both pointers around the non-power-of-two ring several times. The queue is then partly refilled. Only then does the flush cycle raise all three requests together. Two instances, one per storage style, run in lockstep on the same stimulus, and their ports are compared on every cycle.

// File: rtl/ffq_pkg.sv
package ffq_pkg;

  // Kind of pointer movement requested in a cycle
  typedef enum logic [1:0] {
    MOVE_NONE = 2'b00,
    MOVE_PUSH = 2'b01,
    MOVE_POP  = 2'b10,
    MOVE_BOTH = 2'b11
  } move_e;

  function automatic int ptr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/ffq_ptr.sv
module ffq_ptr #(
  parameter int DEPTH = 5,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_nxt
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_inc;

  // Wrap explicitly so non-power-of-two depths stay inside the ring
  always_comb begin
    if (ptr_q == LAST) ptr_inc = '0;
    else               ptr_inc = ptr_q + AW'(1);
  end

  always_comb begin
    if (rst || clr) ptr_nxt = '0;
    else if (adv)   ptr_nxt = ptr_inc;
    else            ptr_nxt = ptr_q;
  end

  always_ff @(posedge clk) begin
    ptr_q <= ptr_nxt;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/ffq_store.sv
module ffq_store #(
  parameter int DEPTH     = 5,
  parameter int WIDTH     = 8,
  parameter int AW        = 3,
  parameter bit SYNC_READ = 1'b1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  input  logic [AW-1:0]    raddr_nxt,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    if (SYNC_READ) begin : g_sync
      // Read one cycle ahead at the next head address; forward a write
      // that lands on that address in the same cycle.
      logic [WIDTH-1:0] rd_q;
      always_ff @(posedge clk) begin
        if (we && (waddr == raddr_nxt)) rd_q <= wdata;
        else                            rd_q <= mem[raddr_nxt];
      end
      assign rdata = rd_q;
      logic unused_raddr;
      assign unused_raddr = ^raddr;
    end else begin : g_comb
      assign rdata = mem[raddr];
      logic unused_nxt;
      assign unused_nxt = ^raddr_nxt;
    end
  endgenerate

endmodule

// File: rtl/ffq_ctrl.sv
module ffq_ctrl
  import ffq_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int AW    = 3,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          in_valid,
  input  logic          out_ready,
  input  logic [AW-1:0] wptr,
  input  logic [AW-1:0] rptr,
  output logic          in_ready,
  output logic          out_valid,
  output logic          push,
  output logic          pop,
  output logic [CW-1:0] count
);

  logic  wrapped_q;
  logic  same_slot;
  logic  full;
  logic  empty;
  move_e move;

  assign same_slot = (wptr == rptr);
  assign full      = same_slot && wrapped_q;
  assign empty     = same_slot && !wrapped_q;

  assign in_ready  = !full;
  assign out_valid = !empty;

  // Stored writes are suppressed during flush; a read handshake is not
  assign push = in_valid && !full && !flush;
  assign pop  = out_ready && !empty;

  assign move = move_e'({pop, push});

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wrapped_q <= 1'b0;
    end else begin
      case (move)
        MOVE_PUSH: wrapped_q <= 1'b1;
        MOVE_POP:  wrapped_q <= 1'b0;
        default:   wrapped_q <= wrapped_q;
      endcase
    end
  end

  always_comb begin
    if (full)
      count = CW'(DEPTH);
    else if (wptr >= rptr)
      count = CW'(wptr) - CW'(rptr);
    else
      count = CW'(DEPTH) - CW'(rptr) + CW'(wptr);
  end

endmodule

// File: rtl/fifo_flush_q.sv
module fifo_flush_q
  import ffq_pkg::*;
#(
  parameter int DEPTH     = 5,
  parameter int WIDTH     = 8,
  parameter bit SYNC_READ = 1'b1,
  localparam int AW       = ptr_bits(DEPTH),
  localparam int CW       = cnt_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic [CW-1:0]    count
);

  logic          push;
  logic          pop;
  logic [AW-1:0] wptr;
  logic [AW-1:0] wptr_nxt;
  logic [AW-1:0] rptr;
  logic [AW-1:0] rptr_nxt;
  logic          unused_wnxt;

  assign unused_wnxt = ^wptr_nxt;

  ffq_ctrl #(
    .DEPTH(DEPTH),
    .AW   (AW),
    .CW   (CW)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .wptr     (wptr),
    .rptr     (rptr),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .push     (push),
    .pop      (pop),
    .count    (count)
  );

  ffq_ptr #(
    .DEPTH(DEPTH),
    .AW   (AW)
  ) u_wptr (
    .clk    (clk),
    .rst    (rst),
    .clr    (flush),
    .adv    (push),
    .ptr    (wptr),
    .ptr_nxt(wptr_nxt)
  );

  ffq_ptr #(
    .DEPTH(DEPTH),
    .AW   (AW)
  ) u_rptr (
    .clk    (clk),
    .rst    (rst),
    .clr    (flush),
    .adv    (pop),
    .ptr    (rptr),
    .ptr_nxt(rptr_nxt)
  );

  ffq_store #(
    .DEPTH    (DEPTH),
    .WIDTH    (WIDTH),
    .AW       (AW),
    .SYNC_READ(SYNC_READ)
  ) u_store (
    .clk      (clk),
    .we       (push),
    .waddr    (wptr),
    .wdata    (in_data),
    .raddr    (rptr),
    .raddr_nxt(rptr_nxt),
    .rdata    (out_data)
  );

endmodule

// File: rtl/ffq_chk.sv
module ffq_chk #(
  parameter int DEPTH = 5,
  parameter int WIDTH = 8,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data,
  input logic [CW-1:0]    count
);

  logic in_fire;
  logic out_fire;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0) && !out_valid && in_ready); // R3

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R7

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH)) |-> !in_ready); // R1

  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> !out_valid); // R1

  AST_HEAD_DURING_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (flush && count != '0) |-> out_valid); // R5

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    (!flush && in_fire && !out_fire) |=> count == $past(count) + CW'(1)); // R2

  AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!flush && in_fire && out_fire) |=> count == $past(count)); // R7

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!flush && out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R2

endmodule

bind fifo_flush_q ffq_chk #(
  .DEPTH(DEPTH),
  .WIDTH(WIDTH),
  .CW   (CW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .flush    (flush),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .count    (count)
);

// File: tb/sim_fifo_flush_q.sv
module sim_fifo_flush_q;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 5;
  localparam int WIDTH      = 8;
  localparam int CW         = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             flush = 1'b0;
  logic             in_valid = 1'b0;
  logic             out_ready = 1'b0;
  logic [WIDTH-1:0] in_data = '0;

  logic             a_in_ready, b_in_ready;
  logic             a_out_valid, b_out_valid;
  logic [WIDTH-1:0] a_out_data, b_out_data;
  logic [CW-1:0]    a_count, b_count;

  int n_chk  = 0;
  int n_fail = 0;
  logic [WIDTH-1:0] mdl[$];
  logic [WIDTH-1:0] nxt_word = 8'h20;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifo_flush_q #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SYNC_READ(1'b1)) u0 (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_ready(a_in_ready), .in_data(in_data),
    .out_valid(a_out_valid), .out_ready(out_ready), .out_data(a_out_data),
    .count(a_count)
  );

  fifo_flush_q #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SYNC_READ(1'b0)) u1 (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_ready(b_in_ready), .in_data(in_data),
    .out_valid(b_out_valid), .out_ready(out_ready), .out_data(b_out_data),
    .count(b_count)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // One cycle: drive, observe the handshake before the edge, update the model,
  // then check the registered state after the edge.
  task automatic step(input bit push, input bit pop, input bit fl, input string tag);
    bit pf, qf;
    logic [WIDTH-1:0] d;
    d = nxt_word;
    in_valid = push; in_data = d; out_ready = pop; flush = fl;
    #1;
    chk(a_in_ready == b_in_ready && a_out_valid == b_out_valid && a_count == b_count,
        "R9 storage styles agree on control", int'(b_count), int'(a_count));
    if (a_out_valid)
      chk(a_out_data == b_out_data, "R9 storage styles agree on data",
          int'(b_out_data), int'(a_out_data));
    pf = push && a_in_ready;
    qf = pop && a_out_valid;
    if (push) nxt_word = nxt_word + 8'd1;
    if (qf) begin
      chk(mdl.size() > 0 && a_out_data == mdl[0], {tag, " head word"},
          int'(a_out_data), (mdl.size() > 0) ? int'(mdl[0]) : -1);
      void'(mdl.pop_front());
    end
    if (fl) mdl.delete();
    else if (pf) mdl.push_back(d);
    @(posedge clk); #1;
    in_valid = 1'b0; out_ready = 1'b0; flush = 1'b0;
    chk(int'(a_count) == mdl.size(), fl ? "R3 count after flush" : "R7 count",
        int'(a_count), mdl.size());
    chk(a_out_valid == (mdl.size() != 0), fl ? "R3 out_valid after flush" : "R1 out_valid",
        int'(a_out_valid), int'(mdl.size() != 0));
    chk(a_in_ready == (mdl.size() < DEPTH), fl ? "R3 in_ready after flush" : "R1 in_ready",
        int'(a_in_ready), int'(mdl.size() < DEPTH));
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 2 * DEPTH && mdl.size() > 0; i++) step(1'b0, 1'b1, 1'b0, tag);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    mdl.delete();
    chk(a_count == '0, "R8 count after reset", int'(a_count), 0);
    chk(!a_out_valid, "R8 out_valid after reset", int'(a_out_valid), 0);
    chk(a_in_ready, "R8 in_ready after reset", int'(a_in_ready), 1);
  endtask

  task automatic t_fill_drain;
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 1'b0, "R2");
    chk(!a_in_ready, "R1 full blocks input", int'(a_in_ready), 0);
    step(1'b1, 1'b0, 1'b0, "R1");  // refused offer, model unchanged
    drain("R2 order after fill");
  endtask

  task automatic t_stream;
    step(1'b1, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b0, "R7");
    // Pointers circle the 5-entry ring several times at constant count
    for (int i = 0; i < 3 * DEPTH + 2; i++) step(1'b1, 1'b1, 1'b0, "R9 wrap");
    chk(int'(a_count) == 2, "R7 count steady under push+pop", int'(a_count), 2);
    drain("R2 order after wrap");
  endtask

  task automatic t_flush_full;
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b1, "R3");
    chk(a_count == '0 && !a_out_valid && a_in_ready, "R3 full queue flushed",
        int'(a_count), 0);
    step(1'b1, 1'b0, 1'b0, "R3");
    drain("R3 order after flush");
  endtask

  task automatic t_flush_enq_deq;
    logic [WIDTH-1:0] expect_w;
    // Move pointers off zero first
    step(1'b1, 1'b0, 1'b0, "R9");
    step(1'b1, 1'b1, 1'b0, "R9");
    step(1'b1, 1'b1, 1'b0, "R9");
    step(1'b1, 1'b0, 1'b0, "R9");
    step(1'b1, 1'b0, 1'b0, "R9");
    chk(a_out_valid, "R5 head present before flush", int'(a_out_valid), 1);
    // Flush with a dequeue (delivers head) and an enqueue (dropped)
    step(1'b1, 1'b1, 1'b1, "R5 dequeue during flush");
    expect_w = nxt_word;
    step(1'b1, 1'b0, 1'b0, "R4");
    step(1'b1, 1'b0, 1'b0, "R4");
    in_valid = 1'b0; out_ready = 1'b1; #1;
    chk(a_out_data == expect_w, "R4 first word after flush", int'(a_out_data), int'(expect_w));
    out_ready = 1'b0;
    drain("R4 order after flush");
  endtask

  task automatic t_flush_empty;
    step(1'b0, 1'b0, 1'b1, "R6");
    step(1'b0, 1'b1, 1'b1, "R6");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R6");
    drain("R6 order after empty flush");
  endtask

  task automatic t_no_bypass;
    in_valid = 1'b1; in_data = 8'hA5; #1;
    chk(!a_out_valid && !b_out_valid, "R10 out_valid with offer to empty queue",
        int'(a_out_valid), 0);
    in_valid = 1'b0;
    step(1'b1, 1'b0, 1'b0, "R10");
    chk(a_out_valid, "R10 word visible next cycle", int'(a_out_valid), 1);
    drain("R10");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_drain();
    t_stream();
    t_flush_full();
    t_flush_enq_deq();
    t_flush_empty();
    t_no_bypass();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R8");
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule